// File: doc/BRIEF.md
# ROM-Operand Multiply-Accumulate Slice

This block is a registered signed multiply-accumulate datapath for a DSP column. Two 18-bit inputs, `b_in` and `d_in`, meet in a pre-adder that either adds them or forms `b_in - d_in`. The 19-bit result is multiplied by an 18-bit coefficient. The coefficient comes from the `a_in` port, or from a small built-in coefficient table whose contents are fixed by a parameter.

The 37-bit product is added to, or subtracted from, a 48-bit accumulation operand. That operand comes from a neighbouring slice's result, from this slice's own result, or is zero, and it can first be shifted right arithmetically by 17 bits. The 48-bit `c_in` and the single-bit `carry_in` are then added.

A second pipeline register on `b_in` feeds a delayed copy of B to the next slice in a chain. Each data register and each control register can be bypassed through a parameter. Each one also has an enable and a synchronous clear or load. A shared active-low asynchronous load brings the slice to a known state.

Top module: `macc_rom_slice`

## Requirements
- R1: When `use_rom` is 1, the coefficient captured into the A register is table word `rom_addr`, which is bits `[18*k+17 : 18*k]` of `ROM_INIT` for address k. When `use_rom` is 0, it is `a_in`.
- R2: The pre-adder output is the 19-bit signed value `B + D`, or `B - D` when the registered pre-subtract control is 1.
- R3: The next result is `E + A*(B±D) + C + carry`, or `E - A*(B±D) + C + carry` when the registered accumulate-subtract control is 1. All values are signed two's complement and the result is truncated to 48 bits.
- R4: The registered 2-bit E select gives E = 0 for code 00, the slice's own result P for codes 01 and 11, and `e_casc_in` for code 10.
- R5: When the registered shift control is 1, E is shifted right arithmetically by 17 bits before it is accumulated.
- R6: `b2_out` is B delayed through the B register and the B2 register. `b_casc_out` always equals `b2_out`.
- R7: `p_casc_out` always equals `p_out`.
- R8: With every register in use, inputs applied before clock edge k appear on `p_out` after edge k+1. An input to `b_in` also appears on `b2_out` after edge k+1.
- R9: While `aload_n` is low, the A, B, B2 and P registers hold zero at once, without waiting for a clock edge. Each control register holds the complement of its own asynchronous-load parameter. The D and C registers are not affected.
- R10: A registered stage whose enable is low and whose synchronous clear or load is inactive keeps its value across a clock edge.
- R11: A low synchronous clear zeroes its data register at the next edge, whatever the enable. A low synchronous load sets its control register to the complement of its synchronous-load parameter at the next edge, whatever the enable.
- R12: A stage whose bypass parameter is 1 passes its input straight through. With every stage except P bypassed, the result appears one edge after its inputs, and `b2_out` follows `b_in` with no delay.
- R13: The own-result feedback codes (bit 0 of the E select set) are never used while P is bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| aload_n | input | 1 | Asynchronous load, active low |
| use_rom | input | 1 | 1 selects the coefficient table for A |
| rom_addr | input | 4 | Coefficient table address |
| a_in | input | 18 | External coefficient |
| a_en | input | 1 | A register enable |
| a_srst_n | input | 1 | A register synchronous clear, active low |
| b_in | input | 18 | Pre-adder operand B |
| b_en | input | 1 | B register enable |
| b_srst_n | input | 1 | B register synchronous clear, active low |
| b2_en | input | 1 | B2 register enable |
| b2_srst_n | input | 1 | B2 register synchronous clear, active low |
| b2_out | output | 18 | Delayed copy of B |
| b_casc_out | output | 18 | Cascade copy of B2 |
| d_in | input | 18 | Pre-adder operand D |
| d_en | input | 1 | D register enable |
| d_srst_n | input | 1 | D register synchronous clear, active low |
| c_in | input | 48 | Addend C |
| carry_in | input | 1 | Carry added with C |
| c_en | input | 1 | C/carry register enable |
| c_srst_n | input | 1 | C/carry register synchronous clear, active low |
| e_casc_in | input | 48 | Result of the previous slice in the chain |
| p_out | output | 48 | Result |
| p_casc_out | output | 48 | Cascade copy of the result |
| p_en | input | 1 | P register enable |
| p_srst_n | input | 1 | P register synchronous clear, active low |
| pre_sub | input | 1 | 1 makes the pre-adder subtract D from B |
| pre_sub_en | input | 1 | Pre-subtract register enable |
| pre_sub_sload_n | input | 1 | Pre-subtract synchronous load, active low |
| acc_sub | input | 1 | 1 subtracts the product |
| acc_sub_en | input | 1 | Accumulate-subtract register enable |
| acc_sub_sload_n | input | 1 | Accumulate-subtract synchronous load, active low |
| shr17 | input | 1 | 1 shifts E right by 17 |
| shr17_en | input | 1 | Shift register enable |
| shr17_sload_n | input | 1 | Shift register synchronous load, active low |
| e_sel | input | 2 | E source select |
| e_sel_en | input | 1 | E select register enable |
| e_sel_sload_n | input | 1 | E select synchronous load, active low |

## Verification
A wrong coefficient, pre-adder sign, E source or shift shows up as a wrong `p_out` one edge after the operand registers load. With own-result feedback selected, the error is then carried into every later result, so it cannot fade away. A wrong B or B2 register shows up on `b2_out` within two edges. A control register that takes the wrong value on an asynchronous or synchronous load corrupts the very first result computed after that load. The bench compares both cascade outputs and both results against a behavioural model on every clock. It does this for a fully registered slice and for one in which every stage except P is bypassed.

// File: rtl/macc_rom_pkg.sv
`timescale 1ns/1ps
package macc_rom_pkg;
   localparam logic [1:0] ESRC_ZERO = 2'b00;
   localparam logic [1:0] ESRC_OWN  = 2'b01;
   localparam logic [1:0] ESRC_CASC = 2'b10;
   localparam logic [1:0] ESRC_OWN2 = 2'b11;
endpackage

// File: rtl/macc_data_reg.sv
`timescale 1ns/1ps
module macc_data_reg #(
   parameter int W         = 18,
   parameter bit BYPASS    = 1'b0,
   parameter bit HAS_ALOAD = 1'b1
) (
   input  logic         clk,
   input  logic         aload_n,
   input  logic         en,
   input  logic         srst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic unused_ok;
   assign unused_ok = ^{clk, aload_n, en, srst_n};

   generate
      if (W < 1) begin : g_bad_w
         $error("macc_data_reg: W must be positive");
      end
      if (BYPASS) begin : g_byp
         assign q = d;
      end else if (HAS_ALOAD) begin : g_al
         always_ff @(posedge clk or negedge aload_n) begin
            if (!aload_n)     q <= '0;
            else if (!srst_n) q <= '0;
            else if (en)      q <= d;
         end
         assert_aload_zero_R9: assert property (@(posedge clk) !aload_n |-> q == '0);
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!srst_n)  q <= '0;
            else if (en)  q <= d;
         end
      end
      if (!BYPASS) begin : g_chk
         assert_srst_clears_R11: assert property (@(posedge clk) disable iff (!aload_n)
            !srst_n |=> q == '0);
         assert_hold_R10: assert property (@(posedge clk) disable iff (!aload_n)
            (srst_n && !en) |=> q == $past(q));
      end
   endgenerate
endmodule

// File: rtl/macc_ctl_reg.sv
`timescale 1ns/1ps
module macc_ctl_reg #(
   parameter int           W           = 1,
   parameter bit           BYPASS      = 1'b0,
   parameter logic [W-1:0] ALOAD_N_VAL = '1,
   parameter logic [W-1:0] SLOAD_N_VAL = '1
) (
   input  logic         clk,
   input  logic         aload_n,
   input  logic         en,
   input  logic         sload_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic unused_ok;
   assign unused_ok = ^{clk, aload_n, en, sload_n};

   generate
      if (BYPASS) begin : g_byp
         assign q = d;
      end else begin : g_reg
         always_ff @(posedge clk or negedge aload_n) begin
            if (!aload_n)      q <= ~ALOAD_N_VAL;
            else if (!sload_n) q <= ~SLOAD_N_VAL;
            else if (en)       q <= d;
         end
         assert_ctl_aload_R9: assert property (@(posedge clk) !aload_n |-> q == ~ALOAD_N_VAL);
         assert_ctl_sload_R11: assert property (@(posedge clk) disable iff (!aload_n)
            !sload_n |=> q == ~SLOAD_N_VAL);
         assert_ctl_hold_R10: assert property (@(posedge clk) disable iff (!aload_n)
            (sload_n && !en) |=> q == $past(q));
      end
   endgenerate
endmodule

// File: rtl/macc_coef_rom.sv
`timescale 1ns/1ps
module macc_coef_rom #(
   parameter int                 W     = 18,
   parameter int                 DEPTH = 16,
   parameter logic [DEPTH*W-1:0] INIT  = '0,
   localparam int                AW    = $clog2(DEPTH)
) (
   input  logic [AW-1:0] addr,
   output logic [W-1:0]  word
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("macc_coef_rom: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   assign word = INIT[addr*W +: W];
endmodule

// File: rtl/macc_rom_slice.sv
`timescale 1ns/1ps
module macc_rom_slice
   import macc_rom_pkg::*;
#(
   parameter int                     OP_W            = 18,
   parameter int                     ACC_W           = 48,
   parameter int                     ROM_DEPTH       = 16,
   parameter int                     E_SHIFT         = 17,
   parameter logic [ROM_DEPTH*OP_W-1:0] ROM_INIT     = '0,
   parameter bit                     A_BYPASS        = 1'b0,
   parameter bit                     B_BYPASS        = 1'b0,
   parameter bit                     B2_BYPASS       = 1'b0,
   parameter bit                     D_BYPASS        = 1'b0,
   parameter bit                     C_BYPASS        = 1'b0,
   parameter bit                     P_BYPASS        = 1'b0,
   parameter bit                     PRE_SUB_BYPASS  = 1'b0,
   parameter bit                     ACC_SUB_BYPASS  = 1'b0,
   parameter bit                     SHR_BYPASS      = 1'b0,
   parameter bit                     ESEL_BYPASS     = 1'b0,
   parameter logic                   PRE_SUB_ALOAD_N = 1'b1,
   parameter logic                   PRE_SUB_SLOAD_N = 1'b1,
   parameter logic                   ACC_SUB_ALOAD_N = 1'b1,
   parameter logic                   ACC_SUB_SLOAD_N = 1'b1,
   parameter logic                   SHR_ALOAD_N     = 1'b1,
   parameter logic                   SHR_SLOAD_N     = 1'b1,
   parameter logic [1:0]             ESEL_ALOAD_N    = 2'b11,
   parameter logic [1:0]             ESEL_SLOAD_N    = 2'b11,
   localparam int                    ROM_AW          = $clog2(ROM_DEPTH),
   localparam int                    PRE_W           = OP_W + 1,
   localparam int                    PROD_W          = 2 * OP_W + 1
) (
   input  logic              clk,
   input  logic              aload_n,
   input  logic              use_rom,
   input  logic [ROM_AW-1:0] rom_addr,
   input  logic [OP_W-1:0]   a_in,
   input  logic              a_en,
   input  logic              a_srst_n,
   input  logic [OP_W-1:0]   b_in,
   input  logic              b_en,
   input  logic              b_srst_n,
   input  logic              b2_en,
   input  logic              b2_srst_n,
   output logic [OP_W-1:0]   b2_out,
   output logic [OP_W-1:0]   b_casc_out,
   input  logic [OP_W-1:0]   d_in,
   input  logic              d_en,
   input  logic              d_srst_n,
   input  logic [ACC_W-1:0]  c_in,
   input  logic              carry_in,
   input  logic              c_en,
   input  logic              c_srst_n,
   input  logic [ACC_W-1:0]  e_casc_in,
   output logic [ACC_W-1:0]  p_out,
   output logic [ACC_W-1:0]  p_casc_out,
   input  logic              p_en,
   input  logic              p_srst_n,
   input  logic              pre_sub,
   input  logic              pre_sub_en,
   input  logic              pre_sub_sload_n,
   input  logic              acc_sub,
   input  logic              acc_sub_en,
   input  logic              acc_sub_sload_n,
   input  logic              shr17,
   input  logic              shr17_en,
   input  logic              shr17_sload_n,
   input  logic [1:0]        e_sel,
   input  logic              e_sel_en,
   input  logic              e_sel_sload_n
);
   generate
      if (PROD_W > ACC_W) begin : g_bad_acc
         $error("macc_rom_slice: ACC_W too narrow for the product");
      end
      if (E_SHIFT < 1 || E_SHIFT >= ACC_W) begin : g_bad_shift
         $error("macc_rom_slice: E_SHIFT out of range");
      end
   endgenerate

   // operand A source
   logic [OP_W-1:0] rom_word, a_sel, a_q;
   macc_coef_rom #(.W(OP_W), .DEPTH(ROM_DEPTH), .INIT(ROM_INIT)) u_rom (
      .addr(rom_addr), .word(rom_word));
   assign a_sel = use_rom ? rom_word : a_in;

   // data registers
   logic [OP_W-1:0]  b_q, b2_q, d_q;
   logic [ACC_W:0]   c_q;
   logic [ACC_W-1:0] p_next, p_q;

   macc_data_reg #(.W(OP_W), .BYPASS(A_BYPASS), .HAS_ALOAD(1'b1)) u_a_reg (
      .clk(clk), .aload_n(aload_n), .en(a_en), .srst_n(a_srst_n), .d(a_sel), .q(a_q));
   macc_data_reg #(.W(OP_W), .BYPASS(B_BYPASS), .HAS_ALOAD(1'b1)) u_b_reg (
      .clk(clk), .aload_n(aload_n), .en(b_en), .srst_n(b_srst_n), .d(b_in), .q(b_q));
   macc_data_reg #(.W(OP_W), .BYPASS(B2_BYPASS), .HAS_ALOAD(1'b1)) u_b2_reg (
      .clk(clk), .aload_n(aload_n), .en(b2_en), .srst_n(b2_srst_n), .d(b_q), .q(b2_q));
   macc_data_reg #(.W(OP_W), .BYPASS(D_BYPASS), .HAS_ALOAD(1'b0)) u_d_reg (
      .clk(clk), .aload_n(aload_n), .en(d_en), .srst_n(d_srst_n), .d(d_in), .q(d_q));
   macc_data_reg #(.W(ACC_W+1), .BYPASS(C_BYPASS), .HAS_ALOAD(1'b0)) u_c_reg (
      .clk(clk), .aload_n(aload_n), .en(c_en), .srst_n(c_srst_n),
      .d({carry_in, c_in}), .q(c_q));
   macc_data_reg #(.W(ACC_W), .BYPASS(P_BYPASS), .HAS_ALOAD(1'b1)) u_p_reg (
      .clk(clk), .aload_n(aload_n), .en(p_en), .srst_n(p_srst_n), .d(p_next), .q(p_q));

   // control registers
   logic       pre_sub_q, acc_sub_q, shr_q;
   logic [1:0] esel_q;

   macc_ctl_reg #(.W(1), .BYPASS(PRE_SUB_BYPASS), .ALOAD_N_VAL(PRE_SUB_ALOAD_N),
                  .SLOAD_N_VAL(PRE_SUB_SLOAD_N)) u_pre_sub_reg (
      .clk(clk), .aload_n(aload_n), .en(pre_sub_en), .sload_n(pre_sub_sload_n),
      .d(pre_sub), .q(pre_sub_q));
   macc_ctl_reg #(.W(1), .BYPASS(ACC_SUB_BYPASS), .ALOAD_N_VAL(ACC_SUB_ALOAD_N),
                  .SLOAD_N_VAL(ACC_SUB_SLOAD_N)) u_acc_sub_reg (
      .clk(clk), .aload_n(aload_n), .en(acc_sub_en), .sload_n(acc_sub_sload_n),
      .d(acc_sub), .q(acc_sub_q));
   macc_ctl_reg #(.W(1), .BYPASS(SHR_BYPASS), .ALOAD_N_VAL(SHR_ALOAD_N),
                  .SLOAD_N_VAL(SHR_SLOAD_N)) u_shr_reg (
      .clk(clk), .aload_n(aload_n), .en(shr17_en), .sload_n(shr17_sload_n),
      .d(shr17), .q(shr_q));
   macc_ctl_reg #(.W(2), .BYPASS(ESEL_BYPASS), .ALOAD_N_VAL(ESEL_ALOAD_N),
                  .SLOAD_N_VAL(ESEL_SLOAD_N)) u_esel_reg (
      .clk(clk), .aload_n(aload_n), .en(e_sel_en), .sload_n(e_sel_sload_n),
      .d(e_sel), .q(esel_q));

   // pre-adder and multiplier
   logic signed [PRE_W-1:0]  pre_sum;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  prod_ext;
   always_comb begin
      if (pre_sub_q) pre_sum = PRE_W'($signed(b_q)) - PRE_W'($signed(d_q));
      else           pre_sum = PRE_W'($signed(b_q)) + PRE_W'($signed(d_q));
   end
   assign prod     = $signed(a_q) * pre_sum;
   assign prod_ext = ACC_W'(prod);

   // accumulation operand E
   logic [ACC_W-1:0]        e_raw;
   logic signed [ACC_W-1:0] e_val;
   always_comb begin
      unique case (esel_q)
         ESRC_ZERO: e_raw = '0;
         ESRC_CASC: e_raw = e_casc_in;
         ESRC_OWN, ESRC_OWN2: e_raw = p_q;
         default:   e_raw = '0;
      endcase
   end
   assign e_val = shr_q ? ($signed(e_raw) >>> E_SHIFT) : $signed(e_raw);

   // final sum
   logic [ACC_W-1:0] cin_ext;
   assign cin_ext = {{(ACC_W-1){1'b0}}, c_q[ACC_W]};
   always_comb begin
      if (acc_sub_q) p_next = e_val - prod_ext + c_q[ACC_W-1:0] + cin_ext;
      else           p_next = e_val + prod_ext + c_q[ACC_W-1:0] + cin_ext;
   end

   assign p_out      = p_q;
   assign p_casc_out = p_q;
   assign b2_out     = b2_q;
   assign b_casc_out = b2_q;

   // checks
   generate
      if (P_BYPASS) begin : g_fb_guard
         assert_no_self_fb_R13: assert property (@(posedge clk) disable iff (!aload_n)
            !esel_q[0]);
      end
      if (!A_BYPASS) begin : g_a_chk
         assert_rom_select_R1: assert property (@(posedge clk) disable iff (!aload_n)
            (a_en && a_srst_n && use_rom) |=> a_q == $past(rom_word));
      end
      if (!B2_BYPASS) begin : g_b2_chk
         assert_b2_follows_R6: assert property (@(posedge clk) disable iff (!aload_n)
            (b2_en && b2_srst_n) |=> b2_q == $past(b_q));
      end
   endgenerate
endmodule

// File: tb/macc_rom_slice_tb.sv
`timescale 1ns/1ps
module macc_rom_slice_tb;
   function automatic logic [17:0] tbw(int i);
      logic [17:0] w;
      w = 18'(i * 2917 + 777);
      w[17] = i[0];
      return w;
   endfunction

   function automatic logic [287:0] build_rom();
      logic [287:0] r;
      r = '0;
      for (int i = 0; i < 16; i++) r[i*18 +: 18] = tbw(i);
      return r;
   endfunction

   localparam logic [287:0] TB_ROM = build_rom();

   function automatic logic [47:0] calc(logic [17:0] a, logic [17:0] b, logic [17:0] d,
                                        logic [47:0] c, logic cin, logic [47:0] ecas,
                                        logic [47:0] p, logic psub, logic asub, logic shr,
                                        logic [1:0] sel);
      longint sa, pre, prod, e, r;
      sa  = longint'($signed(a));
      pre = psub ? longint'($signed(b)) - longint'($signed(d))
                 : longint'($signed(b)) + longint'($signed(d));
      prod = sa * pre;
      if (sel == 2'b00)      e = 0;
      else if (sel == 2'b10) e = longint'($signed(ecas));
      else                   e = longint'($signed(p));
      if (shr) e = e >>> 17;
      r = asub ? e - prod : e + prod;
      r = r + longint'({16'h0, c}) + longint'(cin);
      return r[47:0];
   endfunction

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        aload_n = 1'b1;
   logic        use_rom = 0;
   logic [3:0]  rom_addr = 0;
   logic [17:0] a_in = 0, b_in = 0, d_in = 0;
   logic        a_en = 1, a_srst_n = 1, b_en = 1, b_srst_n = 1, b2_en = 1, b2_srst_n = 1;
   logic        d_en = 1, d_srst_n = 1, c_en = 1, c_srst_n = 1, p_en = 1, p_srst_n = 1;
   logic [47:0] c_in = 0, e_casc_in = 0;
   logic        carry_in = 0;
   logic        pre_sub = 0, pre_sub_en = 1, pre_sub_sload_n = 1;
   logic        acc_sub = 0, acc_sub_en = 1, acc_sub_sload_n = 1;
   logic        shr17 = 0, shr17_en = 1, shr17_sload_n = 1;
   logic [1:0]  e_sel = 0;
   logic        e_sel_en = 1, e_sel_sload_n = 1;

   logic [17:0] b2_out, b_casc_out, b2_out_byp, b_casc_out_byp;
   logic [47:0] p_out, p_casc_out, p_out_byp, p_casc_out_byp;

   macc_rom_slice #(.ROM_INIT(TB_ROM), .PRE_SUB_ALOAD_N(1'b0)) u_dut (
      .clk(clk), .aload_n(aload_n), .use_rom(use_rom), .rom_addr(rom_addr), .a_in(a_in),
      .a_en(a_en), .a_srst_n(a_srst_n), .b_in(b_in), .b_en(b_en), .b_srst_n(b_srst_n),
      .b2_en(b2_en), .b2_srst_n(b2_srst_n), .b2_out(b2_out), .b_casc_out(b_casc_out),
      .d_in(d_in), .d_en(d_en), .d_srst_n(d_srst_n), .c_in(c_in), .carry_in(carry_in),
      .c_en(c_en), .c_srst_n(c_srst_n), .e_casc_in(e_casc_in), .p_out(p_out),
      .p_casc_out(p_casc_out), .p_en(p_en), .p_srst_n(p_srst_n), .pre_sub(pre_sub),
      .pre_sub_en(pre_sub_en), .pre_sub_sload_n(pre_sub_sload_n), .acc_sub(acc_sub),
      .acc_sub_en(acc_sub_en), .acc_sub_sload_n(acc_sub_sload_n), .shr17(shr17),
      .shr17_en(shr17_en), .shr17_sload_n(shr17_sload_n), .e_sel(e_sel),
      .e_sel_en(e_sel_en), .e_sel_sload_n(e_sel_sload_n));

   macc_rom_slice #(.ROM_INIT(TB_ROM), .A_BYPASS(1'b1), .B_BYPASS(1'b1), .B2_BYPASS(1'b1),
                    .D_BYPASS(1'b1), .C_BYPASS(1'b1), .PRE_SUB_BYPASS(1'b1),
                    .ACC_SUB_BYPASS(1'b1), .SHR_BYPASS(1'b1), .ESEL_BYPASS(1'b1)) u_dut_byp (
      .clk(clk), .aload_n(aload_n), .use_rom(use_rom), .rom_addr(rom_addr), .a_in(a_in),
      .a_en(a_en), .a_srst_n(a_srst_n), .b_in(b_in), .b_en(b_en), .b_srst_n(b_srst_n),
      .b2_en(b2_en), .b2_srst_n(b2_srst_n), .b2_out(b2_out_byp), .b_casc_out(b_casc_out_byp),
      .d_in(d_in), .d_en(d_en), .d_srst_n(d_srst_n), .c_in(c_in), .carry_in(carry_in),
      .c_en(c_en), .c_srst_n(c_srst_n), .e_casc_in(e_casc_in), .p_out(p_out_byp),
      .p_casc_out(p_casc_out_byp), .p_en(p_en), .p_srst_n(p_srst_n), .pre_sub(pre_sub),
      .pre_sub_en(pre_sub_en), .pre_sub_sload_n(pre_sub_sload_n), .acc_sub(acc_sub),
      .acc_sub_en(acc_sub_en), .acc_sub_sload_n(acc_sub_sload_n), .shr17(shr17),
      .shr17_en(shr17_en), .shr17_sload_n(shr17_sload_n), .e_sel(e_sel),
      .e_sel_en(e_sel_en), .e_sel_sload_n(e_sel_sload_n));

   // reference model
   logic [17:0] ma = 0, mb = 0, mb2 = 0, md = 0;
   logic [47:0] mc = 0, mp = 0, bp = 0;
   logic        mcin = 0, mpre = 1, msub = 0, mshr = 0;
   logic [1:0]  msel = 0;
   logic [17:0] asel;
   assign asel = use_rom ? tbw(int'(rom_addr)) : a_in;

   always @(posedge clk or negedge aload_n) begin
      if (!aload_n) begin
         ma <= 0; mb <= 0; mb2 <= 0; mp <= 0; bp <= 0;
         mpre <= 1'b1; msub <= 1'b0; mshr <= 1'b0; msel <= 2'b00;
      end else begin
         if (!p_srst_n) mp <= 0;
         else if (p_en) mp <= calc(ma, mb, md, mc, mcin, e_casc_in, mp, mpre, msub, mshr, msel);
         if (!p_srst_n) bp <= 0;
         else if (p_en) bp <= calc(asel, b_in, d_in, c_in, carry_in, e_casc_in, bp,
                                   pre_sub, acc_sub, shr17, e_sel);
         if (!a_srst_n) ma <= 0; else if (a_en) ma <= asel;
         if (!b_srst_n) mb <= 0; else if (b_en) mb <= b_in;
         if (!b2_srst_n) mb2 <= 0; else if (b2_en) mb2 <= mb;
         if (!pre_sub_sload_n) mpre <= 1'b0; else if (pre_sub_en) mpre <= pre_sub;
         if (!acc_sub_sload_n) msub <= 1'b0; else if (acc_sub_en) msub <= acc_sub;
         if (!shr17_sload_n) mshr <= 1'b0; else if (shr17_en) mshr <= shr17;
         if (!e_sel_sload_n) msel <= 2'b00; else if (e_sel_en) msel <= e_sel;
      end
   end

   always @(posedge clk) begin
      if (!d_srst_n) md <= 0; else if (d_en) md <= d_in;
      if (!c_srst_n) begin mc <= 0; mcin <= 0; end
      else if (c_en) begin mc <= c_in; mcin <= carry_in; end
   end

   // checking
   int    checks = 0, fails = 0;
   string tag = "R9 reset";
   bit    active = 0;
   bit    done = 0;

   task automatic chk(string what, logic [47:0] act, logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (active) begin
         chk("p_out", p_out, mp);
         chk("p_casc_out R7", p_casc_out, p_out);
         chk("b2_out R6", {30'h0, b2_out}, {30'h0, mb2});
         chk("b_casc_out R6", {30'h0, b_casc_out}, {30'h0, b2_out});
         chk("bypassed p_out R12", p_out_byp, bp);
         chk("bypassed b2_out R12", {30'h0, b2_out_byp}, {30'h0, b_in});
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         fails++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic rnd_data();
      a_in = 18'($urandom); b_in = 18'($urandom); d_in = 18'($urandom);
      c_in = {16'($urandom), 32'($urandom)}; carry_in = 1'($urandom);
      e_casc_in = {16'($urandom), 32'($urandom)};
      rom_addr = 4'($urandom); use_rom = 1'($urandom);
   endtask

   initial begin
      #1 aload_n = 0; d_srst_n = 0; c_srst_n = 0;
      repeat (3) step();
      active = 1;
      step();
      // R9: complement load of pre-subtract, held with enable low
      tag = "R9 complement";
      aload_n = 1; d_srst_n = 1; c_srst_n = 1; pre_sub_en = 0;
      a_in = 18'd300; b_in = 18'd50; d_in = 18'd20;
      repeat (3) step();
      pre_sub_en = 1;
      // R1: every table word
      tag = "R1 rom operand";
      use_rom = 1; d_in = 0; c_in = 0;
      for (int k = 0; k < 16; k++) begin
         rom_addr = 4'(k); b_in = 18'($urandom); step();
      end
      use_rom = 0;
      repeat (4) begin a_in = 18'($urandom); b_in = 18'($urandom); step(); end
      // R2: pre-adder sign
      tag = "R2 pre-adder";
      repeat (20) begin rnd_data(); pre_sub = 1'($urandom); step(); end
      // R4 / R5: E source and shift
      tag = "R4 R5 own feedback";
      e_sel = 2'b01;
      repeat (12) begin rnd_data(); shr17 = 1'($urandom); step(); end
      tag = "R4 R5 cascade";
      e_sel = 2'b10;
      repeat (12) begin rnd_data(); shr17 = 1'($urandom); step(); end
      tag = "R4 code 11";
      e_sel = 2'b11; shr17 = 0;
      repeat (6) begin rnd_data(); step(); end
      // R10 / R11: enables, clears, loads
      tag = "R10 R11 enables";
      repeat (80) begin
         rnd_data();
         pre_sub = 1'($urandom); acc_sub = 1'($urandom); shr17 = 1'($urandom);
         e_sel = 2'($urandom);
         a_en = 1'($urandom); b_en = 1'($urandom); b2_en = 1'($urandom);
         d_en = 1'($urandom); c_en = 1'($urandom); p_en = 1'($urandom);
         pre_sub_en = 1'($urandom); acc_sub_en = 1'($urandom);
         shr17_en = 1'($urandom); e_sel_en = 1'($urandom);
         a_srst_n = ($urandom % 6) != 0; b_srst_n = ($urandom % 6) != 0;
         b2_srst_n = ($urandom % 6) != 0; d_srst_n = ($urandom % 6) != 0;
         c_srst_n = ($urandom % 6) != 0; p_srst_n = ($urandom % 6) != 0;
         pre_sub_sload_n = ($urandom % 6) != 0; acc_sub_sload_n = ($urandom % 6) != 0;
         shr17_sload_n = ($urandom % 6) != 0; e_sel_sload_n = ($urandom % 6) != 0;
         step();
      end
      a_en = 1; b_en = 1; b2_en = 1; d_en = 1; c_en = 1; p_en = 1;
      pre_sub_en = 1; acc_sub_en = 1; shr17_en = 1; e_sel_en = 1;
      a_srst_n = 1; b_srst_n = 1; b2_srst_n = 1; d_srst_n = 1; c_srst_n = 1; p_srst_n = 1;
      pre_sub_sload_n = 1; acc_sub_sload_n = 1; shr17_sload_n = 1; e_sel_sload_n = 1;
      // R3 R6 R7 R8 R12: full random operation
      tag = "R3 R6 R7 R8 R12 random";
      repeat (250) begin
         rnd_data();
         pre_sub = 1'($urandom); acc_sub = 1'($urandom); shr17 = 1'($urandom);
         e_sel = 2'($urandom);
         step();
      end
      // R9: asynchronous load in the middle of operation
      tag = "R9 midrun";
      #1 aload_n = 0;
      step();
      aload_n = 1;
      repeat (6) begin rnd_data(); step(); end
      @(negedge clk);
      #1;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule